// File: doc/BRIEF.md
# Gated Interrupt Request Combiner

The block merges the interrupt flags of four peripheral modules and one system group into one request line for the CPU. Each group has a vector of flags and a matching vector of local enables. A source can raise the request only when the flag, the local enable, the mask bit of its group and the global enable are all set, and no handler is in service. All sources share one priority and one handler address, which is held in a writable vector register.

Software reaches the block through a small register bus (address, write enable, write data, combinational read data). The bus holds the mask register, a control register (global enable and the in-service bit) and the vector register. A read-only pending register shows which groups have an enabled source with its flag set. The CPU pulses `vec_taken` when it branches to the handler, which locks out further requests. It pulses `irq_return` when the handler exits. Software may also clear the lock early to allow nesting.

Top module: `irq_gate_ctrl`

## Requirements
- R1: `irq_req` is a register. It is 1 in the cycle after a clock edge only if, at that edge, global enable was 1, the in-service bit was not being set or held, and some group with its mask bit at 1 had a source with both flag and local enable at 1. A change in flags, enables, mask or global enable reaches `irq_req` exactly one cycle after that change is visible.
- R2: The mask register sits at address 0. Bits 0 to 3 mask modules 0 to 3 and bit 7 masks the system group. Bits 6:4 and 15:8 are not stored and read as 0, so writing FFFFh reads back 008Fh.
- R3: Pending is a register at address 3 and on the `pending` port. Bit g (g = 0..3) is 1 when module g, on flag/enable bits [8g+7:8g], had a source with flag and enable both 1 at the previous edge. Bit 7 does the same for the system group on bits [39:32]. Mask and global enable do not affect it.
- R4: A pending bit returns to 0 one cycle after every enabled flag of its group is dropped, whether by clearing the flag or clearing its enable.
- R5: Writes to address 3 have no effect on the pending register.
- R6: A `vec_taken` pulse sets the in-service bit (control bit 1), and `irq_req` is 0 from that same clock edge onward.
- R7: `irq_return` clears the in-service bit. A control write with bit 1 at 0 also clears it. A control write with bit 1 at 1 never sets it. `vec_taken` wins over both in the same cycle.
- R8: The vector register at address 2 is 16 bits wide, resets to 0000h and drives `irq_vector`.
- R9: After reset, `irq_req`, `pending`, `irq_vector` and every readable register are 0.
- R10: The control register at address 1 holds global enable in bit 0 (written directly) and reads back in-service in bit 1. `reg_rdata` shows the register selected by `reg_addr`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| flags_i | input | 40 | Source flags, 8 per group, group 4 = system |
| local_en_i | input | 40 | Per-source local enables, same layout |
| reg_we | input | 1 | Register write enable |
| reg_addr | input | 2 | Register address (0 mask, 1 control, 2 vector, 3 pending) |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Read data of the addressed register |
| vec_taken | input | 1 | CPU branched to the handler |
| irq_return | input | 1 | Handler returned |
| irq_req | output | 1 | Interrupt request to the CPU |
| irq_vector | output | 16 | Handler address |
| pending | output | 8 | Per-group pending summary |

## Verification
The bench aims at the in-service lock. A design that gated the request with the old in-service value would send a second request in the cycle after `vec_taken`. A design that let a control write set the bit would block the line for good. Mask and global-enable writes are applied while flags are held, to expose a request that lags or leads by a cycle. Pending is checked against a mask that disagrees with it, so a design that folds the mask into the summary reads wrong. Writes to the pending address and to reserved mask bits are read back at once, so a stored reserved bit or a writable summary shows up at the port.

// File: rtl/irq_gate_pkg.sv
// Shared constants for the gated interrupt combiner.
// Assumes at most seven peripheral modules, so that the system bit (top bit) stays free.
package irq_gate_pkg;
    localparam int DATA_W = 16;
    localparam int SUM_W  = 8;
    localparam logic [1:0] A_MASK = 2'd0;
    localparam logic [1:0] A_CTRL = 2'd1;
    localparam logic [1:0] A_VECT = 2'd2;
    localparam logic [1:0] A_PEND = 2'd3;

    // Bits of the summary/mask layout that exist for a given module count.
    function automatic logic [SUM_W-1:0] live_bits(input int nmod);
        logic [SUM_W-1:0] v;
        v = '0;
        for (int i = 0; i < nmod; i++) v[i] = 1'b1;
        v[SUM_W-1] = 1'b1;
        return v;
    endfunction
endpackage

// File: rtl/irq_src_reduce.sv
// Reduces each group's flags and local enables to one "has enabled flag" bit
// and places it at the group's summary position. Purely combinational.
module irq_src_reduce
    import irq_gate_pkg::*;
#(
    parameter int NMOD  = 4,
    parameter int SRC_W = 8
) (
    input  logic [(NMOD+1)*SRC_W-1:0] flags_i,
    input  logic [(NMOD+1)*SRC_W-1:0] en_i,
    output logic [SUM_W-1:0]          sum_o
);
    localparam int NGRP = NMOD + 1;

    logic [NGRP-1:0] grp_any;

    genvar g;
    generate
        for (g = 0; g < NGRP; g++) begin : g_grp
            // OR of flag AND enable across one group
            assign grp_any[g] = |(flags_i[g*SRC_W +: SRC_W] & en_i[g*SRC_W +: SRC_W]);
        end
    endgenerate

    // Map groups onto the summary layout: modules low, system at the top bit
    always_comb begin
        sum_o = '0;
        for (int i = 0; i < NMOD; i++) sum_o[i] = grp_any[i];
        sum_o[SUM_W-1] = grp_any[NGRP-1];
    end
endmodule

// File: rtl/irq_regs.sv
// Software-visible state: mask, global enable, in-service lock and vector.
// Provides the next in-service value so the request stage can gate on it.
// Assumes vec_taken and irq_return are single-cycle strobes from the CPU.
module irq_regs
    import irq_gate_pkg::*;
#(
    parameter int NMOD = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [1:0]        reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic              vec_taken,
    input  logic              irq_return,
    input  logic [SUM_W-1:0]  pend_i,
    output logic [SUM_W-1:0]  mask_q,
    output logic              gie_q,
    output logic              ins_q,
    output logic              ins_next,
    output logic [DATA_W-1:0] vec_q,
    output logic [DATA_W-1:0] reg_rdata
);
    localparam logic [SUM_W-1:0] LIVE = live_bits(NMOD);

    logic wr_mask, wr_ctrl, wr_vect;
    assign wr_mask = reg_we && (reg_addr == A_MASK);
    assign wr_ctrl = reg_we && (reg_addr == A_CTRL);
    assign wr_vect = reg_we && (reg_addr == A_VECT);

    // Next in-service value: taking the vector wins, then return or software clear
    always_comb begin
        ins_next = ins_q;
        if (vec_taken)                        ins_next = 1'b1;
        else if (irq_return)                  ins_next = 1'b0;
        else if (wr_ctrl && !reg_wdata[1])    ins_next = 1'b0;
    end

    // Register updates for mask, enable, lock and vector
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
            gie_q  <= 1'b0;
            ins_q  <= 1'b0;
            vec_q  <= '0;
        end else begin
            ins_q <= ins_next;
            if (wr_mask) mask_q <= reg_wdata[SUM_W-1:0] & LIVE;
            if (wr_ctrl) gie_q  <= reg_wdata[0];
            if (wr_vect) vec_q  <= reg_wdata;
        end
    end

    // Read mux of the addressed register
    always_comb begin
        unique case (reg_addr)
            A_MASK:  reg_rdata = {{(DATA_W-SUM_W){1'b0}}, mask_q};
            A_CTRL:  reg_rdata = {{(DATA_W-2){1'b0}}, ins_q, gie_q};
            A_VECT:  reg_rdata = vec_q;
            default: reg_rdata = {{(DATA_W-SUM_W){1'b0}}, pend_i};
        endcase
    end
endmodule

// File: rtl/irq_req_gen.sv
// Registers the pending summary and the gated request.
// Gating uses the next in-service value so the request drops on the same
// edge the vector is taken.
module irq_req_gen
    import irq_gate_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SUM_W-1:0] sum_i,
    input  logic [SUM_W-1:0] mask_q,
    input  logic             gie_q,
    input  logic             ins_next,
    output logic [SUM_W-1:0] pending,
    output logic             irq_req
);
    logic any_masked;
    assign any_masked = |(sum_i & mask_q);

    // Pending summary and request registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending <= '0;
            irq_req <= 1'b0;
        end else begin
            pending <= sum_i;
            irq_req <= gie_q && !ins_next && any_masked;
        end
    end
endmodule

// File: rtl/irq_gate_ctrl.sv
// Top of the gated interrupt combiner: reduces per-source flags, holds the
// software registers and raises one registered request to the CPU.
module irq_gate_ctrl
    import irq_gate_pkg::*;
#(
    parameter int NMOD  = 4,
    parameter int SRC_W = 8,
    localparam int FW   = (NMOD+1)*SRC_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [FW-1:0]     flags_i,
    input  logic [FW-1:0]     local_en_i,
    input  logic              reg_we,
    input  logic [1:0]        reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              vec_taken,
    input  logic              irq_return,
    output logic              irq_req,
    output logic [DATA_W-1:0] irq_vector,
    output logic [SUM_W-1:0]  pending
);
    logic [SUM_W-1:0] sum_c;
    logic [SUM_W-1:0] mask_q;
    logic             gie_q, ins_q, ins_next;

    irq_src_reduce #(.NMOD(NMOD), .SRC_W(SRC_W)) u_reduce (
        .flags_i (flags_i),
        .en_i    (local_en_i),
        .sum_o   (sum_c)
    );

    irq_regs #(.NMOD(NMOD)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .vec_taken (vec_taken),
        .irq_return(irq_return),
        .pend_i    (pending),
        .mask_q    (mask_q),
        .gie_q     (gie_q),
        .ins_q     (ins_q),
        .ins_next  (ins_next),
        .vec_q     (irq_vector),
        .reg_rdata (reg_rdata)
    );

    irq_req_gen u_req (
        .clk     (clk),
        .rst_n   (rst_n),
        .sum_i   (sum_c),
        .mask_q  (mask_q),
        .gie_q   (gie_q),
        .ins_next(ins_next),
        .pending (pending),
        .irq_req (irq_req)
    );
endmodule

// File: rtl/irq_gate_chk.sv
// Protocol checks for irq_gate_ctrl, attached by bind.
module irq_gate_chk
    import irq_gate_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             irq_req,
    input logic             vec_taken,
    input logic             irq_return,
    input logic             gie_q,
    input logic             ins_q,
    input logic [SUM_W-1:0] mask_q
);
    // R1
    req_needs_gie_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> $past(gie_q));
    // R1
    req_not_in_service_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> !ins_q);
    // R6
    taken_locks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vec_taken |=> (ins_q && !irq_req));
    // R7
    return_unlocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_return && !vec_taken) |=> !ins_q);
    // R2
    reserved_mask_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mask_q[6:4] == 3'b000);
endmodule

bind irq_gate_ctrl irq_gate_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq_req   (irq_req),
    .vec_taken (vec_taken),
    .irq_return(irq_return),
    .gie_q     (gie_q),
    .ins_q     (ins_q),
    .mask_q    (mask_q)
);

// File: tb/test_irq_gate_ctrl.sv
module test_irq_gate_ctrl;
    localparam int FW = 40;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [FW-1:0] flags_i = '0, local_en_i = '0;
    logic          reg_we = 1'b0;
    logic [1:0]    reg_addr = 2'd0;
    logic [15:0]   reg_wdata = '0;
    logic [15:0]   reg_rdata;
    logic          vec_taken = 1'b0, irq_return = 1'b0;
    logic          irq_req;
    logic [15:0]   irq_vector;
    logic [7:0]    pending;

    int n_chk = 0, n_bad = 0;

    // bench model of software-visible state
    logic [7:0]  m_mask = '0, m_pend = '0;
    logic        m_gie = 1'b0, m_ins = 1'b0, m_req = 1'b0;
    logic [15:0] m_vec = '0;

    always #4 clk = ~clk;

    irq_gate_ctrl i_irq_gate_ctrl (
        .clk(clk), .rst_n(rst_n), .flags_i(flags_i), .local_en_i(local_en_i),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .vec_taken(vec_taken), .irq_return(irq_return),
        .irq_req(irq_req), .irq_vector(irq_vector), .pending(pending)
    );

    function automatic logic [7:0] sum_of(input logic [FW-1:0] f, input logic [FW-1:0] e);
        logic [7:0] s = '0;
        for (int g = 0; g < 5; g++) begin
            if (g == 4) s[7] = |(f[g*8 +: 8] & e[g*8 +: 8]);
            else        s[g] = |(f[g*8 +: 8] & e[g*8 +: 8]);
        end
        return s;
    endfunction

    function automatic logic [15:0] read_of(input logic [1:0] a);
        case (a)
            2'd0:    return {8'h00, m_mask};
            2'd1:    return {14'h0, m_ins, m_gie};
            2'd2:    return m_vec;
            default: return {8'h00, m_pend};
        endcase
    endfunction

    task automatic chk(input string tag, input string what, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
        end
    endtask

    // One cycle: drive at negedge, model the edge, check 1 ns after it
    task automatic step(input string tag, input logic we, input logic [1:0] a,
                        input logic [15:0] wd, input logic vt, input logic ir,
                        input logic [FW-1:0] f, input logic [FW-1:0] e);
        logic [7:0] s;
        logic       nins;
        reg_we = we; reg_addr = a; reg_wdata = wd;
        vec_taken = vt; irq_return = ir; flags_i = f; local_en_i = e;
        s = sum_of(f, e);
        nins = m_ins;
        if (vt) nins = 1'b1;
        else if (ir) nins = 1'b0;
        else if (we && a == 2'd1 && !wd[1]) nins = 1'b0;
        @(posedge clk);
        m_req = m_gie && !nins && |(s & m_mask);
        m_pend = s;
        m_ins = nins;
        if (we && a == 2'd0) m_mask = wd[7:0] & 8'h8F;
        if (we && a == 2'd1) m_gie = wd[0];
        if (we && a == 2'd2) m_vec = wd;
        #1;
        chk(tag, "irq_req (R1)", {31'b0, irq_req}, {31'b0, m_req});
        chk(tag, "pending (R3)", {24'b0, pending}, {24'b0, m_pend});
        chk(tag, "irq_vector (R8)", {16'b0, irq_vector}, {16'b0, m_vec});
        chk(tag, "reg_rdata (R10)", {16'b0, reg_rdata}, {16'b0, read_of(a)});
        @(negedge clk);
    endtask

    initial begin
        #1600000;
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        logic [FW-1:0] f1, e1;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R9 reset state at the ports and in every register
        chk("R9", "irq_req", {31'b0, irq_req}, 32'd0);
        chk("R9", "pending", {24'b0, pending}, 32'd0);
        chk("R9", "irq_vector", {16'b0, irq_vector}, 32'd0);
        for (int a = 0; a < 4; a++) begin
            reg_addr = 2'(a); #1;
            chk("R9", "reg_rdata", {16'b0, reg_rdata}, 32'd0);
        end
        @(negedge clk);

        // R2 reserved mask bits read as zero
        step("R2", 1, 2'd0, 16'hFFFF, 0, 0, '0, '0);
        chk("R2", "mask readback", {16'b0, reg_rdata}, 32'h008F);
        // R10 global enable written via control
        step("R10", 1, 2'd1, 16'h0001, 0, 0, '0, '0);
        // R1 module 1 bit 3: flag and enable
        f1 = '0; e1 = '0; f1[11] = 1; e1[11] = 1;
        step("R1", 0, 2'd1, 0, 0, 0, f1, e1);
        chk("R1", "request raised", {31'b0, irq_req}, 32'd1);
        // R1 mask off module 1 while flag held
        step("R1", 1, 2'd0, 16'h008D, 0, 0, f1, e1);
        step("R1", 0, 2'd0, 0, 0, 0, f1, e1);
        chk("R1", "masked request", {31'b0, irq_req}, 32'd0);
        chk("R3", "pending ignores mask", {24'b0, pending}, 32'h02);
        // R3 system group goes to bit 7
        f1 = '0; e1 = '0; f1[32] = 1; e1[32] = 1;
        step("R3", 0, 2'd3, 0, 0, 0, f1, e1);
        chk("R3", "system pending", {24'b0, pending}, 32'h80);
        // R4 dropping the enable clears the summary
        step("R4", 0, 2'd3, 0, 0, 0, f1, '0);
        chk("R4", "pending cleared", {24'b0, pending}, 32'h00);
        // R5 writes to pending address do nothing
        step("R5", 1, 2'd3, 16'hFFFF, 0, 0, '0, '0);
        chk("R5", "pending after write", {24'b0, pending}, 32'h00);
        // R6 take the vector on an active request
        step("R6", 0, 2'd1, 0, 0, 0, f1, e1);
        chk("R6", "request before take", {31'b0, irq_req}, 32'd1);
        step("R6", 0, 2'd1, 0, 1, 0, f1, e1);
        chk("R6", "request dropped", {31'b0, irq_req}, 32'd0);
        chk("R6", "in-service read", {16'b0, reg_rdata}, 32'h0003);
        step("R6", 0, 2'd1, 0, 0, 0, f1, e1);
        chk("R6", "still locked", {31'b0, irq_req}, 32'd0);
        // R7 return unlocks
        step("R7", 0, 2'd1, 0, 0, 1, f1, e1);
        chk("R7", "request back", {31'b0, irq_req}, 32'd1);
        // R7 software clear, and set attempt ignored
        step("R7", 0, 2'd1, 0, 1, 0, f1, e1);
        step("R7", 1, 2'd1, 16'h0001, 0, 0, f1, e1);
        chk("R7", "sw clear", {16'b0, reg_rdata}, 32'h0001);
        step("R7", 1, 2'd1, 16'h0003, 0, 0, f1, e1);
        chk("R7", "sw set ignored", {16'b0, reg_rdata}, 32'h0001);
        // R7 take wins over return
        step("R7", 0, 2'd1, 0, 1, 1, f1, e1);
        chk("R7", "take wins", {16'b0, reg_rdata}, 32'h0003);
        step("R7", 0, 2'd1, 0, 0, 1, '0, '0);
        // R8 vector register
        step("R8", 1, 2'd2, 16'h1234, 0, 0, '0, '0);
        chk("R8", "vector", {16'b0, irq_vector}, 32'h1234);

        // mixed random traffic
        for (int i = 0; i < 2000; i++) begin
            logic [FW-1:0] rf, re;
            rf = {$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom};
            re = {$urandom, $urandom} | {$urandom, $urandom};
            if ($urandom % 4 == 0) rf = '0;
            step("RND", ($urandom % 4) == 0, 2'($urandom), 16'($urandom),
                 ($urandom % 8) == 0, ($urandom % 6) == 0, rf, re);
        end

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule